// File: doc/BRIEF.md
# Section Parity Error Checker

This block watches a SONET/SDH byte stream before descrambling and checks section parity. For every byte of a frame it builds an 8-bit bit-interleaved parity: the exclusive OR of all the bytes in the frame. When the frame ends, that value becomes the reference. In the following frame, the byte at the section parity position is compared bit by bit with the reference. Each bit that differs counts as one error.

Errors add into a running counter that stops at its maximum value. Software reads the counter through a latch strobe. The strobe moves the running count into a holding register and restarts the count in the same cycle, so no error is lost across a read. A control input selects block mode, in which a frame with any parity mismatch adds exactly one to the count.

The input is a valid/ready stream that never applies back-pressure. `in_ready` is always high, and a byte counts in every cycle in which `in_valid` is high. The frame-start and parity-position strobes are read only in cycles with a valid byte.

Top module: `sbip_checker`

## Requirements
- R1: The reference parity is the XOR of all valid bytes from one frame-start byte up to, but not including, the next frame-start byte. The parity-position byte is included in this XOR.
- R2: On a valid parity-position byte, `frame_err_bits` is set to the number of bit positions where that byte differs from the reference, a value from 0 to 8. `frame_err_vld` pulses high for the one cycle after that byte.
- R3: The running count holds at 2^CNT_W-1 and never wraps.
- R4: When `latch_req` is high, `err_count` takes the running count, and the running count is reloaded with only the increment from that same cycle.
- R5: When `block_mode` is high, a parity-position byte with one or more differing bits adds exactly 1 to the count. A byte with no differing bits adds 0.
- R6: No comparison happens until one complete frame has been seen after reset, that is, before the second frame-start byte.
- R7: In cycles with `in_valid` low, `in_data`, `in_sof` and `in_b1` have no effect.
- R8: `in_ready` is high in every cycle, including during reset.
- R9: After reset, `err_count`, the running count and `frame_err_vld` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_data | input | 8 | Scrambled stream byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_b1 | input | 1 | Marks the section parity byte |
| block_mode | input | 1 | 1 = add at most one per frame |
| latch_req | input | 1 | Latch-and-clear strobe |
| err_count | output | CNT_W | Latched error count |
| frame_err_bits | output | 4 | Mismatching bits of the last check |
| frame_err_vld | output | 1 | One-cycle pulse after a check |

## Verification
The assertions assume that the parity-position strobe never comes on the same byte as the frame-start strobe, and that it comes at most once per frame. Block mode is then equivalent to one count per frame. The stimulus builds every frame with the frame-start strobe on byte 0 and the parity strobe on byte 3. Between bytes it inserts idle cycles carrying random strobes and data, so the checks confirm that these idle cycles are ignored. `block_mode` changes only between frames.

// File: rtl/sbip_pkg.sv
package sbip_pkg;
  function automatic logic [6:0] popcount64(input logic [63:0] v);
    logic [6:0] n;
    n = '0;
    for (int i = 0; i < 64; i++) n = n + 7'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/sbip_parity_acc.sv
module sbip_parity_acc #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              sof,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] ref_par,
  output logic              ref_ok
);
  logic [DATA_W-1:0] acc;
  logic              started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      started <= 1'b0;
      ref_par <= '0;
      ref_ok  <= 1'b0;
    end else if (byte_vld) begin
      if (sof) begin
        acc     <= data;
        started <= 1'b1;
        if (started) begin
          ref_par <= acc;
          ref_ok  <= 1'b1;
        end
      end else begin
        acc <= acc ^ data;
      end
    end
  end

  // R1: the reference parity only changes on a valid frame-start byte
  p_ref_only_at_sof_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && sof) |=> $stable(ref_par));
  // R6: reference becomes usable only after a frame-start with a frame already open
  p_ref_ok_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ok) |-> $past(started) && $past(byte_vld && sof));
endmodule

// File: rtl/sbip_compare.sv
module sbip_compare
  import sbip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] ref_par,
  input  logic              ref_ok,
  input  logic              block_mode,
  output logic [ERR_W-1:0]  step,
  output logic [ERR_W-1:0]  err_bits,
  output logic              err_vld
);
  logic              do_cmp;
  logic [DATA_W-1:0] diff;
  logic [ERR_W-1:0]  nbits;

  assign do_cmp = chk && ref_ok;
  assign diff   = data ^ ref_par;
  assign nbits  = ERR_W'(popcount64(64'(diff)));

  always_comb begin
    step = '0;
    if (do_cmp) begin
      if (block_mode) step = ERR_W'(nbits != '0);
      else            step = nbits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_bits <= '0;
      err_vld  <= 1'b0;
    end else begin
      err_vld <= do_cmp;
      if (do_cmp) err_bits <= nbits;
    end
  end

  // R6: a result is reported only if the reference was ready at the check
  p_no_cmp_before_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> $past(ref_ok));
  // R2: a result pulse follows a parity-position strobe
  p_vld_follows_chk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> $past(chk));
endmodule

// File: rtl/sbip_err_counter.sv
module sbip_err_counter #(
  parameter int CNT_W = 16,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] step,
  input  logic             latch,
  output logic [CNT_W-1:0] running,
  output logic [CNT_W-1:0] held
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0] sum;
  assign sum = {1'b0, running} + (CNT_W+1)'(step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= '0;
      held    <= '0;
    end else if (latch) begin
      held    <= running;
      running <= CNT_W'(step);
    end else begin
      running <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end
  end

  // R3: without a latch the count never goes down (no wrap)
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> running >= $past(running));
  // R4: a latch moves the running count into the holding register
  p_latch_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> held == $past(running));
  // R4: the holding register changes only on a latch
  p_held_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(held));
endmodule

// File: rtl/sbip_checker.sv
module sbip_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_b1,
  input  logic              block_mode,
  input  logic              latch_req,
  output logic [CNT_W-1:0]  err_count,
  output logic [$clog2(DATA_W+1)-1:0] frame_err_bits,
  output logic              frame_err_vld
);
  localparam int ERR_W = $clog2(DATA_W+1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] ref_par;
  logic              ref_ok;
  logic [ERR_W-1:0]  step;
  logic [CNT_W-1:0]  running;

  assign in_ready = 1'b1;

  sbip_parity_acc #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .byte_vld(in_valid), .sof(in_sof),
    .data(in_data), .ref_par(ref_par), .ref_ok(ref_ok)
  );

  sbip_compare #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .chk(in_valid && in_b1), .data(in_data),
    .ref_par(ref_par), .ref_ok(ref_ok), .block_mode(block_mode),
    .step(step), .err_bits(frame_err_bits), .err_vld(frame_err_vld)
  );

  sbip_err_counter #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .latch(latch_req),
    .running(running), .held(err_count)
  );

  // R5: in block mode the count grows by at most one per cycle
  p_block_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode && !latch_req && running != CNT_MAX) |=>
      (running == $past(running) || running == $past(running) + 1'b1));
  // R7: idle cycles leave the count alone unless a latch arrives
  p_idle_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !latch_req) |=> $stable(running));
  // R2: a reported result never exceeds the byte width
  p_err_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_vld |-> frame_err_bits <= ERR_W'(DATA_W));
endmodule

// File: tb/sbip_checker_tb.sv
module sbip_checker_tb;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_b1 = 1'b0;
  logic block_mode = 1'b0, latch_req = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic [CW-1:0] err_count;
  logic [3:0] frame_err_bits;
  logic frame_err_vld;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R9";

  sbip_checker #(.DATA_W(8), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_b1(in_b1), .block_mode(block_mode),
    .latch_req(latch_req), .err_count(err_count),
    .frame_err_bits(frame_err_bits), .frame_err_vld(frame_err_vld)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int m_acc, m_ref, m_run, m_held, m_bits;
  bit m_started, m_refok, m_vld;

  function automatic int pc(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  always @(posedge clk) begin
    int inc;
    if (!rst_n) begin
      m_acc = 0; m_ref = 0; m_run = 0; m_held = 0; m_bits = 0;
      m_started = 0; m_refok = 0; m_vld = 0;
    end else begin
      inc = 0;
      m_vld = 0;
      if (in_valid) begin
        if (in_b1 && m_refok) begin
          m_bits = pc(int'(in_data) ^ m_ref);
          m_vld = 1;
          inc = block_mode ? (m_bits != 0) : m_bits;
        end
        if (in_sof) begin
          if (m_started) begin m_ref = m_acc; m_refok = 1; end
          m_acc = int'(in_data);
          m_started = 1;
        end else begin
          m_acc = m_acc ^ int'(in_data);
        end
      end
      if (latch_req) begin
        m_held = m_run; m_run = inc;
      end else begin
        m_run = (m_run + inc > CMAX) ? CMAX : m_run + inc;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8", int'(in_ready), 1, "in_ready");
      check(tag, int'(err_count), m_held, "err_count");
      check(tag, int'(frame_err_vld), int'(m_vld), "frame_err_vld");
      if (m_vld) check(tag, int'(frame_err_bits), m_bits, "frame_err_bits");
    end
  end

  task automatic idle_junk(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'($urandom); in_b1 = 1'($urandom);
      in_data = 8'($urandom); latch_req = 1'b0;
    end
  endtask

  // byte 0 = frame start, byte 3 = parity byte (reference XOR mask)
  task automatic send_frame(input int len, input int mask, input int latch_at, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 3 == 0)) idle_junk(1);
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_b1 = (i == 3);
      in_data = (i == 3) ? 8'(m_ref ^ mask) : 8'($urandom);
      latch_req = (i == latch_at);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_b1 = 1'b0; latch_req = 1'b0;
  endtask

  task automatic do_latch();
    @(negedge clk);
    in_valid = 1'b0; latch_req = 1'b1;
    @(negedge clk);
    latch_req = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", int'(err_count), 0, "err_count after reset");
    check("R9", int'(frame_err_vld), 0, "frame_err_vld after reset");
    // R7: junk idle cycles before any frame
    tag = "R7";
    idle_junk(6);
    // R6: first frame cannot be checked
    tag = "R6";
    send_frame(10, 8'hFF, -1, 1'b0);
    do_latch();
    check("R6", int'(err_count), 0, "count after unchecked first frame");
    // R1/R2: varied masks with gaps
    tag = "R2";
    send_frame(10, 8'h00, -1, 1'b1);
    send_frame(12, 8'h01, -1, 1'b1);
    send_frame(9,  8'hA5, -1, 1'b1);
    send_frame(16, 8'hFF, -1, 1'b0);
    tag = "R1";
    send_frame(11, 8'h3C, -1, 1'b1);
    do_latch();
    check("R1", int'(err_count), 0 + 1 + 4 + 8 + 4, "summed mismatches");
    // R4: latch coinciding with the parity byte
    tag = "R4";
    send_frame(10, 8'h07, 3, 1'b0);
    check("R4", int'(err_count), 0, "latch on check cycle");
    do_latch();
    check("R4", int'(err_count), 3, "same-cycle errors kept");
    // R5: block mode
    tag = "R5";
    block_mode = 1'b1;
    send_frame(10, 8'hFF, -1, 1'b1);
    send_frame(10, 8'h00, -1, 1'b1);
    send_frame(10, 8'h81, -1, 1'b0);
    do_latch();
    check("R5", int'(err_count), 2, "block count");
    block_mode = 1'b0;
    // R3: saturation
    tag = "R3";
    for (int f = 0; f < 40; f++) send_frame(8, 8'hFF, -1, 1'b0);
    do_latch();
    check("R3", int'(err_count), CMAX, "saturated count");
    do_latch();
    check("R3", int'(err_count), 0, "cleared after latch");
    idle_junk(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule